// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This block lets a fixed group of hardware agents meet at a common point and continue together, episode after episode, without any clearing phase between episodes. Each agent raises its arrival strobe for one cycle when it reaches the meeting point. The block counts arrivals in a shared counter and keeps one global phase bit. Each agent also has a private phase bit, held inside the block, which flips every time that agent arrives.

The arrival that completes the group returns the counter to zero and sets the global phase bit to the new private phase of the arriving agents. Every agent whose arrival is still outstanding and whose private phase now matches the global bit sees its release output go high. That release is a pulse of one cycle, after which the agent may enter the next episode at once. An agent can even re-arrive in the cycle its release is high. An arrival from an agent that is already waiting is dropped and reported on an error output.

Top module: `barrier_sense_ctrl`

## Requirements
- R1: After reset, the release outputs are all 0, the error output is 0 and the global phase output is 0.
- R2: While fewer than NUM_PART distinct agents have arrived in the current episode, no release output is high.
- R3: In the cycle after the edge that takes in the final arrival, every agent of the episode has its release bit high, and that bit is high for exactly that one cycle.
- R4: Arrivals strobed by several agents in the same cycle are all counted, so all NUM_PART agents arriving in one cycle complete the episode.
- R5: The global phase output (sense_o) inverts at each completed episode and at no other time. Its value is visible from the cycle after the completing edge.
- R6: The barrier can be used again straight away. An agent that strobes arrive in the cycle its release is high is counted towards the next episode, and that next episode again needs all NUM_PART agents.
- R7: An arrival from an agent that is waiting and not being released is ignored and does not count. In the cycle after such an arrival, err_o is high for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arrive_i | input | NUM_PART | Per-agent arrival strobe, one cycle per arrival |
| release_o | output | NUM_PART | Per-agent release pulse |
| sense_o | output | 1 | Global phase bit |
| err_o | output | 1 | Pulse after an ignored duplicate arrival |

## Verification
The embedded properties check several rules on every cycle. The arrival counter never exceeds the group size. The global phase changes only when the counter has returned to zero. Every release happens while the counter is empty. A private phase flips only on an arrival, and an error pulse follows only an arrival strobe. Some behaviour only the directed scenarios can show: episodes staggered over several cycles, a full group arriving in a single cycle, a duplicate that must not shorten an episode, and re-entry during the release cycle. Those scenarios compare the release, phase and error outputs against values worked out in the bench.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  // width of a counter that must hold 0..n inclusive
  function automatic int unsigned count_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/barrier_popcount.sv
module barrier_popcount #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned CW    = 3
) (
  input  logic [WIDTH-1:0] bits_i,
  output logic [CW-1:0]    ones_o
);
  always_comb begin
    ones_o = '0;
    for (int unsigned b = 0; b < WIDTH; b++) begin
      ones_o = ones_o + CW'(bits_i[b]);
    end
  end
endmodule

// File: rtl/barrier_slot.sv
module barrier_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic arrive_i,
  input  logic gsense_i,
  output logic release_o,
  output logic accept_o,
  output logic dup_o
);
  logic waiting_q;
  logic psense_q;

  assign release_o = waiting_q & (psense_q == gsense_i);
  assign accept_o  = arrive_i & (~waiting_q | release_o);
  assign dup_o     = arrive_i & waiting_q & ~release_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting_q <= 1'b0;
      psense_q  <= 1'b0;
    end else if (accept_o) begin
      waiting_q <= 1'b1;
      psense_q  <= ~psense_q;
    end else if (release_o) begin
      waiting_q <= 1'b0;
    end
  end

  // R6
  psense_on_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psense_q != $past(psense_q)) |-> $past(arrive_i));
endmodule

// File: rtl/barrier_episode.sv
module barrier_episode #(
  parameter int unsigned NUM_PART = 4,
  parameter int unsigned CW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] joined_i,
  output logic [CW-1:0] count_o,
  output logic          gsense_o
);
  localparam logic [CW-1:0] FULL = CW'(NUM_PART);

  logic [CW-1:0] count_q;
  logic          gsense_q;
  logic [CW:0]   total;
  logic          complete;

  // pre-update count plus this cycle's joiners decides completion
  assign total    = {1'b0, count_q} + {1'b0, joined_i};
  assign complete = (total == {1'b0, FULL});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      gsense_q <= 1'b0;
    end else if (complete) begin
      count_q  <= '0;
      gsense_q <= ~gsense_q;
    end else begin
      count_q  <= total[CW-1:0];
    end
  end

  assign count_o  = count_q;
  assign gsense_o = gsense_q;

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q < FULL);
  // R5
  flag_flip_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gsense_q != $past(gsense_q)) |-> (count_q == '0));
endmodule

// File: rtl/barrier_sense_ctrl.sv
module barrier_sense_ctrl #(
  parameter int unsigned NUM_PART = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PART-1:0] arrive_i,
  output logic [NUM_PART-1:0] release_o,
  output logic                sense_o,
  output logic                err_o
);
  localparam int unsigned CW = barrier_pkg::count_width(NUM_PART);

  logic [NUM_PART-1:0] accept;
  logic [NUM_PART-1:0] dup;
  logic [CW-1:0]       joined;
  logic [CW-1:0]       count;
  logic                gsense;
  logic                err_q;

  for (genvar g = 0; g < NUM_PART; g++) begin : g_slot
    barrier_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .arrive_i  (arrive_i[g]),
      .gsense_i  (gsense),
      .release_o (release_o[g]),
      .accept_o  (accept[g]),
      .dup_o     (dup[g])
    );
  end

  barrier_popcount #(.WIDTH(NUM_PART), .CW(CW)) u_pop (
    .bits_i (accept),
    .ones_o (joined)
  );

  barrier_episode #(.NUM_PART(NUM_PART), .CW(CW)) u_ep (
    .clk      (clk),
    .rst_n    (rst_n),
    .joined_i (joined),
    .count_o  (count),
    .gsense_o (gsense)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= |dup;
  end

  assign sense_o = gsense;
  assign err_o   = err_q;

  // R3
  release_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|release_o) |-> (count == '0));
  // R7
  err_after_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(|arrive_i));
endmodule

// File: tb/tb_barrier_sense_ctrl.sv
module tb_barrier_sense_ctrl;
  localparam int unsigned N   = 4;
  localparam time         CLK = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] arrive = '0;
  logic [N-1:0] release_o;
  logic         sense_o;
  logic         err_o;

  int tests = 0;
  int fails = 0;
  logic exp_sense = 1'b0;

  always #(CLK/2) clk = ~clk;

  barrier_sense_ctrl #(.NUM_PART(N)) dut (
    .clk(clk), .rst_n(rst_n), .arrive_i(arrive),
    .release_o(release_o), .sense_o(sense_o), .err_o(err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // strobe a mask for one cycle; return at the negedge after the edge that took it
  task automatic strobe(input logic [N-1:0] m);
    @(negedge clk) arrive = m;
    @(negedge clk) arrive = '0;
  endtask

  task automatic t_reset;
    check("R1 release", 32'(release_o), 0);
    check("R1 err", 32'(err_o), 0);
    check("R1 sense", 32'(sense_o), 0);
  endtask

  task automatic t_staggered;
    strobe(4'b0001); check("R2 after 1", 32'(release_o), 0);
    strobe(4'b0010); check("R2 after 2", 32'(release_o), 0);
    strobe(4'b0100); check("R2 after 3", 32'(release_o), 0);
    check("R5 no early flip", 32'(sense_o), 32'(exp_sense));
    strobe(4'b1000); exp_sense = ~exp_sense;
    check("R3 release all", 32'(release_o), 32'hF);
    check("R5 flip", 32'(sense_o), 32'(exp_sense));
    @(negedge clk);
    check("R3 one cycle", 32'(release_o), 0);
  endtask

  task automatic t_simul;
    strobe(4'b1111); exp_sense = ~exp_sense;
    check("R4 simultaneous", 32'(release_o), 32'hF);
    check("R5 flip simul", 32'(sense_o), 32'(exp_sense));
    @(negedge clk);
    check("R3 drop", 32'(release_o), 0);
  endtask

  task automatic t_dup;
    strobe(4'b0001);
    check("R7 no err first", 32'(err_o), 0);
    strobe(4'b0001);
    check("R7 err pulse", 32'(err_o), 1);
    check("R7 no release", 32'(release_o), 0);
    strobe(4'b0110);
    check("R7 dup not counted", 32'(release_o), 0);
    check("R7 err clears", 32'(err_o), 0);
    strobe(4'b1000); exp_sense = ~exp_sense;
    check("R7 completes", 32'(release_o), 32'hF);
    check("R5 flip dup", 32'(sense_o), 32'(exp_sense));
    @(negedge clk);
  endtask

  task automatic t_reentry;
    strobe(4'b0011);
    strobe(4'b0100);
    @(negedge clk) arrive = 4'b1000;
    @(negedge clk) arrive = 4'b0011; exp_sense = ~exp_sense;
    check("R6 release", 32'(release_o), 32'hF);
    @(negedge clk) arrive = '0;
    check("R6 reentry no err", 32'(err_o), 0);
    check("R6 released once", 32'(release_o), 0);
    check("R6 sense held", 32'(sense_o), 32'(exp_sense));
    strobe(4'b0100);
    check("R6 needs all", 32'(release_o), 0);
    strobe(4'b1000); exp_sense = ~exp_sense;
    check("R6 next episode", 32'(release_o), 32'hF);
    check("R5 flip reentry", 32'(sense_o), 32'(exp_sense));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_staggered();
    t_simul();
    t_dup();
    t_reentry();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK * 20000);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule